// File: doc/BRIEF.md
# Scaled Index Adder

This block forms a base-plus-scaled-index value in one registered step. It shifts the index operand B left by one to four bit positions and adds the base operand A. The sum is truncated to the word width and wraps on overflow. No carry or overflow indication is produced. A 2-bit selector picks the shift amount.

A mode input makes the block treat B as an unsigned half-word. The lower half of B is zero-extended to full width before scaling, and the upper half has no effect. A record-form input asks for a signed negative/positive/zero summary of the sum, which is delivered alongside it. Results appear one clock after a valid request. Between requests the outputs hold their last value.

Top module: `scaled_add_unit`

## Requirements
- R1: One clock edge after an edge with `valid_i` high, `sum_o` equals `a_i + (index << shift)` modulo 2^XLEN, where index is B as prepared by the mode.
- R2: Selector value n on `shift_sel_i` (0 to 3) gives a left shift of n+1 bits.
- R3: Zeros fill the vacated low bits, and bits of B shifted beyond bit XLEN-1 are discarded.
- R4: With `uword_i` high, the upper XLEN/2 bits of `b_i` are ignored and the lower XLEN/2 bits are zero-extended before the shift.
- R5: The addition wraps modulo 2^XLEN. A sum that carries out of the top bit keeps only its low XLEN bits.
- R6: With `record_i` high, `cr_o` = {neg, pos, zero} for the sum read as signed: bit 2 for negative, bit 1 for strictly positive, bit 0 for zero. Exactly one bit is set.
- R7: With `record_i` low, `cr_o` is 3'b000 for that result.
- R8: `valid_o` is `valid_i` delayed by one cycle. While `valid_i` is low, `sum_o` and `cr_o` keep their values whatever the other inputs do.
- R9: While `rst_ni` is low, `sum_o`, `cr_o` and `valid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| a_i | input | XLEN | Base operand |
| b_i | input | XLEN | Index operand |
| shift_sel_i | input | 2 | Shift selector, value n shifts by n+1 |
| uword_i | input | 1 | Zero-extend lower half of B before scaling |
| record_i | input | 1 | Produce the signed condition summary |
| sum_o | output | XLEN | Registered sum |
| cr_o | output | 3 | {neg, pos, zero} summary, zero in plain form |
| valid_o | output | 1 | Result strobe |

## Verification
Wrap-around of the addition and the signed summary act on the same result in the same cycle. Directed requests provoke this with sums that carry out to exactly zero, and with sums that carry into the sign bit. The bench judges the summary against a sum it computes itself, truncated to XLEN bits, so that it expects zero and negative rather than a carried value. Truncation of B under the largest shift is paired with the record form in the same way.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NUM_SH  = 1 << SEL_W;
  localparam int unsigned CR_W    = 3;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
  } cr_t;
endpackage

// File: rtl/sa_operand_prep.sv
module sa_operand_prep #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] b_i,
  input  logic            uword_i,
  output logic [XLEN-1:0] idx_o
);
  localparam int unsigned HALF = XLEN / 2;

  always_comb begin
    if (uword_i) idx_o = {{(XLEN-HALF){1'b0}}, b_i[HALF-1:0]};
    else         idx_o = b_i;
  end
endmodule

// File: rtl/sa_scaler.sv
module sa_scaler #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]          idx_i,
  input  logic [sa_pkg::SEL_W-1:0] sel_i,
  output logic [XLEN-1:0]          scaled_o
);
  import sa_pkg::*;

  logic [XLEN-1:0] cand [NUM_SH];

  // candidate k shifts by k+1
  for (genvar k = 0; k < NUM_SH; k++) begin : g_cand
    assign cand[k] = {idx_i[XLEN-2-k:0], {(k+1){1'b0}}};
  end

  assign scaled_o = cand[sel_i];
endmodule

// File: rtl/sa_flag_gen.sv
module sa_flag_gen #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] sum_i,
  input  logic            record_i,
  output sa_pkg::cr_t     cr_o
);
  logic is_zero;

  assign is_zero = (sum_i == '0);

  always_comb begin
    cr_o = '0;
    if (record_i) begin
      cr_o.neg  = sum_i[XLEN-1];
      cr_o.pos  = !sum_i[XLEN-1] && !is_zero;
      cr_o.zero = is_zero;
    end
  end
endmodule

// File: rtl/scaled_add_unit.sv
module scaled_add_unit #(
  parameter int unsigned XLEN = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [XLEN-1:0]          a_i,
  input  logic [XLEN-1:0]          b_i,
  input  logic [sa_pkg::SEL_W-1:0] shift_sel_i,
  input  logic                     uword_i,
  input  logic                     record_i,
  output logic [XLEN-1:0]          sum_o,
  output logic [sa_pkg::CR_W-1:0]  cr_o,
  output logic                     valid_o
);
  import sa_pkg::*;

  logic [XLEN-1:0] idx;
  logic [XLEN-1:0] scaled;
  logic [XLEN-1:0] sum_d;
  cr_t             cr_d;

  sa_operand_prep #(.XLEN(XLEN)) i_prep (
    .b_i     (b_i),
    .uword_i (uword_i),
    .idx_o   (idx)
  );

  sa_scaler #(.XLEN(XLEN)) i_scaler (
    .idx_i    (idx),
    .sel_i    (shift_sel_i),
    .scaled_o (scaled)
  );

  // wraps modulo 2^XLEN, carry dropped
  assign sum_d = a_i + scaled;

  sa_flag_gen #(.XLEN(XLEN)) i_flags (
    .sum_i    (sum_d),
    .record_i (record_i),
    .cr_o     (cr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      cr_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sum_o <= sum_d;
        cr_o  <= cr_d;
      end
    end
  end
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int unsigned XLEN = 64
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    record_i,
  input logic [XLEN-1:0]         sum_o,
  input logic [sa_pkg::CR_W-1:0] cr_o,
  input logic                    valid_o
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R8
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(sum_o) && $stable(cr_o))); // R8
  AST_CR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cr_o)); // R6
  AST_CR_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && record_i) |=> ($countones(cr_o) == 1)); // R6
  AST_CR_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !record_i) |=> (cr_o == '0)); // R7
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_o[0] |-> (sum_o == '0)); // R6
  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_o[2] |-> sum_o[XLEN-1]); // R6
  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (sum_o == '0 && cr_o == '0 && !valid_o); // R9
  end
endmodule

bind scaled_add_unit sa_checker #(.XLEN(XLEN)) i_sa_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .record_i (record_i),
  .sum_o    (sum_o),
  .cr_o     (cr_o),
  .valid_o  (valid_o)
);

// File: tb/test_scaled_add_unit.sv
module test_scaled_add_unit;
  localparam int unsigned XLEN = 64;
  localparam int unsigned HALF = XLEN / 2;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [XLEN-1:0] a_i = '0;
  logic [XLEN-1:0] b_i = '0;
  logic [1:0]      shift_sel_i = '0;
  logic            uword_i = 1'b0;
  logic            record_i = 1'b0;
  logic [XLEN-1:0] sum_o;
  logic [2:0]      cr_o;
  logic            valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  scaled_add_unit #(.XLEN(XLEN)) i_scaled_add_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .shift_sel_i(shift_sel_i), .uword_i(uword_i), .record_i(record_i),
    .sum_o(sum_o), .cr_o(cr_o), .valid_o(valid_o)
  );

  function automatic logic [XLEN-1:0] model_sum(logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                                                logic [1:0] sel, logic uw);
    logic [XLEN-1:0] bb;
    bb = uw ? {{HALF{1'b0}}, b[HALF-1:0]} : b;
    return a + (bb << (int'(sel) + 1));
  endfunction

  function automatic logic [2:0] model_cr(logic [XLEN-1:0] s, logic rec);
    if (!rec) return 3'b000;
    if (s == '0) return 3'b001;
    return s[XLEN-1] ? 3'b100 : 3'b010;
  endfunction

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one request, check result one edge later
  task automatic run_op(string req, logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                        logic [1:0] sel, logic uw, logic rec);
    logic [XLEN-1:0] es;
    es = model_sum(a, b, sel, uw);
    @(negedge clk_i);
    a_i = a; b_i = b; shift_sel_i = sel; uword_i = uw; record_i = rec; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " sum"}, sum_o, es);
    check({req, " cr"}, XLEN'(cr_o), XLEN'(model_cr(es, rec)));
    check({req, " valid"}, XLEN'(valid_o), XLEN'(1'b1));
  endtask

  task automatic t_reset;
    check("R9 sum", sum_o, '0);
    check("R9 cr", XLEN'(cr_o), '0);
    check("R9 valid", XLEN'(valid_o), '0);
  endtask

  task automatic t_shift_codes;
    for (int s = 0; s < 4; s++)
      run_op("R2 R1", 64'h1000, 64'h3, 2'(s), 1'b0, 1'b1);
    run_op("R1", 64'h0123_4567_89ab_cdef, 64'h0000_0fed_cba9_8765, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_truncate;
    run_op("R3", 64'h5, '1, 2'd3, 1'b0, 1'b1);
    run_op("R3", 64'h0, 64'hf000_0000_0000_0001, 2'd3, 1'b0, 1'b0);
  endtask

  task automatic t_uword;
    run_op("R4", 64'h10, 64'hffff_ffff_0000_0007, 2'd0, 1'b1, 1'b1);
    run_op("R4", 64'h0, 64'hffff_ffff_ffff_ffff, 2'd3, 1'b1, 1'b1);
  endtask

  task automatic t_wrap;
    // carry out to exactly zero, and carry into the sign bit
    run_op("R5 R6", 64'hffff_ffff_ffff_fff8, 64'h1, 2'd2, 1'b0, 1'b1);
    run_op("R5 R6", 64'h7fff_ffff_ffff_ffff, 64'h1, 2'd0, 1'b0, 1'b1);
    run_op("R6", 64'hffff_ffff_ffff_ff00, 64'h1, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic t_plain;
    run_op("R7", 64'hffff_ffff_ffff_ff00, 64'h1, 2'd0, 1'b0, 1'b0);
    run_op("R7", 64'h0, 64'h0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    logic [XLEN-1:0] s_prev;
    logic [2:0] c_prev;
    run_op("R8", 64'h42, 64'h8, 2'd1, 1'b0, 1'b1);
    s_prev = sum_o; c_prev = cr_o;
    @(negedge clk_i);
    a_i = '1; b_i = '1; shift_sel_i = 2'd3; record_i = 1'b0; valid_i = 1'b0;
    @(negedge clk_i);
    check("R8 hold sum", sum_o, s_prev);
    check("R8 hold cr", XLEN'(cr_o), XLEN'(c_prev));
    check("R8 idle valid", XLEN'(valid_o), '0);
  endtask

  initial begin
    #3;
    t_reset();
    #10 rst_ni = 1'b1;
    t_shift_codes();
    t_truncate();
    t_uword();
    t_wrap();
    t_plain();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule